// File: doc/BRIEF.md
# Dual-Channel Serial Converter Output Shifter

This block models the digital output half of a two-channel sampling converter's serial port. A host lowers an active-low select line and then toggles a serial clock. The select falling edge is the sample instant. At that edge the block captures two 12-bit results, one for channel A and one for channel B. Both data lines stay undriven during a fixed conversion window of serial clock falling edges. After that, each line shifts out its own channel's word, most significant bit first. If the host keeps select low, the line then shifts out the other channel's word. A line goes quiet again at a hard stop edge, or earlier if select rises.

The select and serial clock pins are asynchronous to the block. Each passes through a two-flop synchronizer with edge detection in the system clock domain, and the system clock must run at least four times the serial clock rate. A frame state machine has four states. ST_IDLE waits for the select falling edge. ST_CONVERT counts conversion edges. ST_SHIFT enables the lines and shifts data. ST_DONE holds the lines undriven until select rises.

The transitions are: IDLE to CONVERT on a select fall; CONVERT to SHIFT on the 19th counted falling edge; SHIFT to DONE on the 45th; and CONVERT, SHIFT or DONE back to IDLE on a select rise. One shift-register lane per output line loads {own word, other word} on entry to CONVERT.

Top module: `dual_adc_serializer`

## Requirements
- R1: Both channel results are captured when the select falling edge is detected. Changes on the result inputs afterwards do not affect the words shifted out in that frame.
- R2: Before the 19th counted serial clock falling edge, both output enables are low.
- R3: On the 19th counted falling edge, both enables rise together, and each line presents bit 11 of its own channel (line A carries channel A, line B carries channel B).
- R4: Each later falling edge advances one bit, MSB first, so edge 19+k shows bit 11-k and edge 30 shows bit 0.
- R5: On edges 31 to 42, line A carries channel B's word and line B carries channel A's word, MSB first. On edges 43 and 44 both lines drive 0 while still enabled.
- R6: On the 45th counted falling edge, both enables fall and stay low until select rises.
- R7: A select rising edge forces both enables low and returns the block to idle, so the next select fall starts a fresh count at zero.
- R8: A serial clock falling edge that arrives together with the select falling edge is not counted. The next falling edge is edge 1.
- R9: The busy output is high from the select fall until the enables return low (edge 45 or select rise), and low otherwise.
- R10: A data line reads 0 whenever its enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, idles high |
| chan_a_res | input | 12 | Channel A conversion result |
| chan_b_res | input | 12 | Channel B conversion result |
| dout_a | output | 1 | Serial data line A |
| dout_a_oe | output | 1 | Drive enable for line A (low = high impedance) |
| dout_b | output | 1 | Serial data line B |
| dout_b_oe | output | 1 | Drive enable for line B (low = high impedance) |
| busy | output | 1 | Frame in progress |

## Verification
The bench targets the select-coincident serial clock edge. A design that counted it would shift every bit one edge early and enable the lines on edge 18. It holds select low past edge 45 to confirm that the lines stay quiet in ST_DONE rather than wrapping or continuing to shift. It changes the result inputs right after the select fall: a design that sampled them late would emit the new values. Random frames end at arbitrary edge counts, before, during and after the chained second word, to show that an early select rise disables both lines and that the next frame starts counting from one.

// File: rtl/adcser_pkg.sv
`timescale 1ns/1ps
package adcser_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_SHIFT,
        ST_DONE
    } frame_state_e;
endpackage

// File: rtl/sig_sync.sv
`timescale 1ns/1ps
module sig_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {(STAGES+1){RESET_VAL}};
        end else begin
            pipe <= {pipe[STAGES-1:0], async_in};
        end
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/frame_ctrl.sv
`timescale 1ns/1ps
module frame_ctrl
    import adcser_pkg::*;
#(
    parameter int CONV_EDGES = 19,
    parameter int STOP_EDGE  = 45,
    parameter int CNT_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk_fall,
    output logic             load,
    output logic             shift,
    output logic             lane_oe,
    output logic             busy,
    output logic [CNT_W-1:0] cnt
);
    frame_state_e state, state_nx;
    logic         edge_ok;

    assign edge_ok = sclk_fall & ~cs_rise;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cs_fall) state_nx = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (cs_rise)
                    state_nx = ST_IDLE;
                else if (sclk_fall && cnt == CNT_W'(CONV_EDGES-1))
                    state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_rise)
                    state_nx = ST_IDLE;
                else if (sclk_fall && cnt == CNT_W'(STOP_EDGE-1))
                    state_nx = ST_DONE;
            end
            ST_DONE: begin
                if (cs_rise) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE || cs_rise)
                cnt <= '0;
            else if (edge_ok && (state == ST_CONVERT || state == ST_SHIFT))
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        load    = (state == ST_IDLE) && cs_fall;
        shift   = (state == ST_SHIFT) && edge_ok;
        lane_oe = (state == ST_SHIFT);
        busy    = (state == ST_CONVERT) || (state == ST_SHIFT);
    end
endmodule

// File: rtl/out_lane.sv
`timescale 1ns/1ps
module out_lane #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              oe,
    input  logic [DATA_W-1:0] own_word,
    input  logic [DATA_W-1:0] other_word,
    output logic              dout
);
    localparam int SR_W = 2 * DATA_W;
    logic [SR_W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sreg <= '0;
        else if (load)
            sreg <= {own_word, other_word};
        else if (shift)
            sreg <= {sreg[SR_W-2:0], 1'b0};
    end

    assign dout = oe & sreg[SR_W-1];
endmodule

// File: rtl/dual_adc_serializer.sv
`timescale 1ns/1ps
module dual_adc_serializer #(
    parameter int DATA_W      = 12,
    parameter int CONV_EDGES  = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] chan_a_res,
    input  logic [DATA_W-1:0] chan_b_res,
    output logic              dout_a,
    output logic              dout_a_oe,
    output logic              dout_b,
    output logic              dout_b_oe,
    output logic              busy
);
    localparam int STOP_EDGE = CONV_EDGES + 2 * DATA_W + 2;
    localparam int CNT_W     = $clog2(STOP_EDGE + 1);
    localparam int LANES     = 2;

    logic             cs_level, cs_fall, cs_rise;
    logic             sclk_level, sclk_rise, sclk_fall;
    logic             load, shift, lane_oe;
    logic [CNT_W-1:0] cnt;
    logic [LANES-1:0] lane_dout;

    sig_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cs_n),
        .level(cs_level), .rise(cs_rise), .fall(cs_fall)
    );

    sig_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sclk),
        .level(sclk_level), .rise(sclk_rise), .fall(sclk_fall)
    );

    frame_ctrl #(
        .CONV_EDGES(CONV_EDGES), .STOP_EDGE(STOP_EDGE), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sclk_fall),
        .load(load), .shift(shift), .lane_oe(lane_oe),
        .busy(busy), .cnt(cnt)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        out_lane #(.DATA_W(DATA_W)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .load(load), .shift(shift), .oe(lane_oe),
            .own_word  ((g == 0) ? chan_a_res : chan_b_res),
            .other_word((g == 0) ? chan_b_res : chan_a_res),
            .dout(lane_dout[g])
        );
    end

    assign dout_a    = lane_dout[0];
    assign dout_b    = lane_dout[1];
    assign dout_a_oe = lane_oe;
    assign dout_b_oe = lane_oe;
endmodule

// File: rtl/dual_adc_serializer_chk.sv
`timescale 1ns/1ps
module dual_adc_serializer_chk #(
    parameter int DATA_W     = 12,
    parameter int CONV_EDGES = 19,
    parameter int CNT_W      = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             cs_fall,
    input logic             sclk_fall,
    input logic [CNT_W-1:0] cnt,
    input logic             dout_a,
    input logic             dout_a_oe,
    input logic             dout_b,
    input logic             dout_b_oe,
    input logic             busy
);
    localparam int STOP_EDGE = CONV_EDGES + 2 * DATA_W + 2;

    p_lanes_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dout_a_oe == dout_b_oe);

    p_oe_rise_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_a_oe) |-> $past(sclk_fall) && (cnt == CNT_W'(CONV_EDGES)));

    p_dout_a_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_a_oe |-> !dout_a);

    p_dout_b_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_b_oe |-> !dout_b);

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(STOP_EDGE));

    p_cs_high_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)
        |-> !busy && !dout_a_oe);

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_fall));
endmodule

bind dual_adc_serializer dual_adc_serializer_chk #(
    .DATA_W(DATA_W), .CONV_EDGES(CONV_EDGES), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_fall(cs_fall),
    .sclk_fall(sclk_fall), .cnt(cnt),
    .dout_a(dout_a), .dout_a_oe(dout_a_oe),
    .dout_b(dout_b), .dout_b_oe(dout_b_oe), .busy(busy)
);

// File: tb/tb_dual_adc_serializer.sv
`timescale 1ns/1ps
module tb_dual_adc_serializer;
    localparam int DW    = 12;
    localparam int CONV  = 19;
    localparam int STOP  = CONV + 2 * DW + 2;
    localparam int HALF  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b1;
    logic [DW-1:0] chan_a_res = '0;
    logic [DW-1:0] chan_b_res = '0;
    logic          dout_a, dout_a_oe, dout_b, dout_b_oe, busy;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    dual_adc_serializer dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .chan_a_res(chan_a_res), .chan_b_res(chan_b_res),
        .dout_a(dout_a), .dout_a_oe(dout_a_oe),
        .dout_b(dout_b), .dout_b_oe(dout_b_oe), .busy(busy)
    );

    function automatic logic exp_bit(logic [DW-1:0] own, logic [DW-1:0] other, int e);
        int k;
        if (e < CONV || e >= STOP) return 1'b0;
        k = e - CONV;
        if (k < DW) return own[DW-1-k];
        if (k < 2*DW) return other[2*DW-1-k];
        return 1'b0;
    endfunction

    function automatic logic exp_oe(int e);
        return (e >= CONV) && (e < STOP);
    endfunction

    function automatic string tag_for(int e, bit coin);
        if (coin) return "R8";
        if (e < CONV) return "R2";
        if (e == CONV) return "R3";
        if (e <= CONV + DW - 1) return "R4";
        if (e < STOP) return "R5";
        return "R6";
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic run_frame(logic [DW-1:0] a, logic [DW-1:0] b, int n, bit coin);
        string t;
        chan_a_res = a;
        chan_b_res = b;
        @(negedge clk);
        cs_n = 1'b0;
        if (coin) sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        // R1: results move after capture; frame must still show a and b
        chan_a_res = ~a;
        chan_b_res = ~b;
        chk("R9", "busy after select fall", busy, 1'b1);
        chk("R2", "oe during conversion", dout_a_oe, 1'b0);
        if (coin) begin
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        for (int e = 1; e <= n; e++) begin
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
            t = tag_for(e, coin);
            chk(t, "oe_a", dout_a_oe, exp_oe(e));
            chk(t, "oe_b", dout_b_oe, exp_oe(e));
            chk((e >= CONV && e < STOP && !coin) ? "R1" : t, "dout_a", dout_a, exp_bit(a, b, e));
            chk(t, "dout_b", dout_b, exp_bit(b, a, e));
            chk("R9", "busy", busy, (e < STOP) ? 1'b1 : 1'b0);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
        chk("R7", "oe after select rise", dout_a_oe | dout_b_oe, 1'b0);
        chk("R9", "busy after select rise", busy, 1'b0);
        chk("R10", "data quiet after select rise", dout_a | dout_b, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2", "reset oe_a", dout_a_oe, 1'b0);
        chk("R9", "reset busy", busy, 1'b0);
        chk("R10", "reset dout_a", dout_a, 1'b0);

        // directed corners
        run_frame(12'hFFF, 12'h000, STOP + 2, 1'b0);
        run_frame(12'hA5A, 12'h3C3, 31, 1'b0);
        run_frame(12'h801, 12'h7FE, STOP + 1, 1'b1);
        run_frame(12'h123, 12'hFED, CONV, 1'b0);
        run_frame(12'h0F0, 12'hF0F, 10, 1'b0);
        run_frame(12'h555, 12'hAAA, CONV + 3, 1'b0);

        for (int f = 0; f < 10; f++) begin
            run_frame(DW'($urandom_range(0, 4095)), DW'($urandom_range(0, 4095)),
                      int'($urandom_range(5, STOP + 3)), bit'($urandom_range(0, 1)));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule